// File: doc/BRIEF.md
# Page-Mode Read Controller for Asynchronous DRAM

This block sits between a synchronous read requester and an asynchronous DRAM with a multiplexed address bus. It takes one row/column read request at a time through a valid/ready port. It drives the row and column addresses on a shared bus, one after the other, and sequences the active-low row strobe, column strobe, write enable and output enable. It samples the DRAM data bus at the end of the column strobe and returns the word through a response port. A one-cycle `rsp_valid` pulse marks each returned word. The response port has no back-pressure, so the consumer must take every word in the cycle it is presented.

After a read, the row strobe stays low and the row is tracked as open. A later request to the same row skips the row phase and repeats only the column phase. A request to a different row first precharges: the row strobe goes high for a set number of cycles, then a full row cycle starts. If no request arrives for a set number of cycles, the page is closed so that the row strobe is never held low indefinitely.

The parameter `EDO` selects extended data-out behaviour. With it set, output enable stays low between column cycles of an open page, and `rsp_data` holds the last word until the next response. With it clear, output enable is low only while the column strobe is low, and `rsp_data` is zero outside the valid pulse. All strobe widths are integer cycle counts, each at least 1.

Top module: `dram_page_reader`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_addr` is 0, `rsp_valid` is 0 and `req_ready` is 1 with no row open.
- R2: A read to a closed row puts the row on `dram_addr` for one cycle with the row strobe still high. The row strobe then falls and stays low for TRCD cycles with the row address held. The column address then appears for one cycle before the column strobe falls. `dram_we_n` is always 1.
- R3: The column strobe stays low for exactly TCAS cycles, with the column address stable. Output enable is low during that time.
- R4: While a row is open, a request with the same row causes no new fall of the row strobe. Between successive column-strobe pulses in one page, the column strobe is high for at least TCP cycles.
- R5: A request to a different row while a page is open raises the row strobe, keeps it high for at least TRP cycles, and then runs a full row cycle. A rising row strobe marks the row as closed.
- R6: With a page open and `req_valid` low, the row strobe rises exactly IDLE_LIMIT cycles after the page has entered its idle wait, which begins TCP cycles after the response pulse. It does not rise earlier.
- R7: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the controller waits with the page closed or open. It is 0 from the cycle after acceptance until that request's column pulse has ended and the column precharge has elapsed.
- R8: Every accepted request yields exactly one `rsp_valid` pulse of one cycle, in acceptance order. `rsp_data` equals the value on `dram_dq` in the last cycle of that request's column pulse.
- R9: With EDO = 0, output enable is 1 whenever the column strobe is 1, and `rsp_data` is 0 whenever `rsp_valid` is 0.
- R10: With EDO = 1, output enable stays 0 while the column strobe is high between column cycles of an open page. `rsp_data` keeps the last returned word until the next `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds a returned word |
| rsp_data | output | DATA_W | Returned read word |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address to the DRAM |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low, held inactive |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | input | DATA_W | Data bus from the DRAM |

## Verification
The hardest case to reach is the boundary between a page hit and an idle close. This happens when a same-row request arrives just before or just after the idle counter expires. In that case the controller either reuses the open row or pays a precharge and a full row cycle. Random gaps between requests are drawn over a range that crosses IDLE_LIMIT, and rows are drawn from a set of four, so hits, misses and idle closes all occur. The bench memory model returns a word keyed by the row it latched at the row-strobe fall and the column present during the column strobe. Any mistake in address multiplexing or page tracking therefore shows up as wrong data. Directed cases pin down exactly when the idle close happens.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [3:0] {
    ST_CLOSED,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_CP,
    ST_OPEN,
    ST_PRE
  } ctl_state_e;

  function automatic int max_of2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_cycle_timer.sv
module dram_cycle_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dram_open_row.sv
module dram_open_row #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             is_open,
  output logic             hit
);
  logic [ROW_W-1:0] row_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      vld_q <= 1'b0;
    end else if (open_clr) begin
      vld_q <= 1'b0;
    end else if (open_set) begin
      row_q <= set_row;
      vld_q <= 1'b1;
    end
  end

  assign is_open = vld_q;
  assign hit     = vld_q && (cmp_row == row_q);
endmodule

// File: rtl/dram_idle_watch.sv
module dram_idle_watch #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic counting,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!counting) cnt_q <= '0;
    else if (!expire)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire = counting && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/dram_page_reader.sv
module dram_page_reader
  import dram_pkg::*;
#(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 8,
  parameter int DATA_W     = 16,
  parameter int TRCD       = 2,
  parameter int TCAS       = 2,
  parameter int TCP        = 1,
  parameter int TRP        = 2,
  parameter int IDLE_LIMIT = 8,
  parameter bit EDO        = 1'b0,
  localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  input  logic [DATA_W-1:0] dram_dq
);
  localparam int TMAX = max_of2(max_of2(TRCD, TCAS), max_of2(TCP, TRP));
  localparam int TW   = $clog2(TMAX + 1);

  ctl_state_e       st_q, st_nx;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             fire;
  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic             row_open, row_hit;
  logic             idle_expire;
  logic             pend_row_q;
  logic             page_rd_q;
  logic             oe_act;

  assign req_ready = (st_q == ST_CLOSED) || (st_q == ST_OPEN);
  assign fire      = req_valid && req_ready;

  dram_cycle_timer #(.W(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  dram_open_row #(.ROW_W(ROW_W)) rowtrk_i (
    .clk(clk), .rst_n(rst_n),
    .open_set(st_q == ST_ROW), .open_clr(st_q == ST_PRE),
    .set_row(row_q), .cmp_row(req_row),
    .is_open(row_open), .hit(row_hit)
  );

  dram_idle_watch #(.LIMIT(IDLE_LIMIT)) idle_i (
    .clk(clk), .rst_n(rst_n),
    .counting((st_q == ST_OPEN) && !req_valid),
    .expire(idle_expire)
  );

  always_comb begin
    st_nx    = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_CLOSED: if (fire) st_nx = ST_ROW;
      ST_ROW: begin
        st_nx    = ST_RAS;
        tmr_load = 1'b1;
        tmr_val  = TW'(TRCD - 1);
      end
      ST_RAS: if (tmr_zero) st_nx = ST_COL;
      ST_COL: begin
        st_nx    = ST_CAS;
        tmr_load = 1'b1;
        tmr_val  = TW'(TCAS - 1);
      end
      ST_CAS: if (tmr_zero) begin
        st_nx    = ST_CP;
        tmr_load = 1'b1;
        tmr_val  = TW'(TCP - 1);
      end
      ST_CP: if (tmr_zero) st_nx = ST_OPEN;
      ST_OPEN: begin
        if (fire && row_hit) begin
          st_nx = ST_COL;
        end else if (fire || idle_expire) begin
          st_nx    = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = TW'(TRP - 1);
        end
      end
      ST_PRE: if (tmr_zero) st_nx = pend_row_q ? ST_ROW : ST_CLOSED;
      default: st_nx = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_CLOSED;
      row_q      <= '0;
      col_q      <= '0;
      pend_row_q <= 1'b0;
      page_rd_q  <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (fire) begin
        row_q <= req_row;
        col_q <= req_col;
      end
      if (st_q == ST_OPEN) pend_row_q <= fire;
      if (st_q == ST_PRE)      page_rd_q <= 1'b0;
      else if (st_q == ST_CAS) page_rd_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (st_q == ST_CAS) && tmr_zero;
      if ((st_q == ST_CAS) && tmr_zero) rsp_data <= dram_dq;
      else if (!EDO)                    rsp_data <= '0;
    end
  end

  always_comb begin
    case (st_q)
      ST_ROW, ST_RAS:                 dram_addr = ADDR_W'(row_q);
      ST_COL, ST_CAS, ST_CP, ST_OPEN: dram_addr = ADDR_W'(col_q);
      default:                        dram_addr = '0;
    endcase
  end

  assign dram_ras_n = !((st_q == ST_RAS) || (st_q == ST_COL) || (st_q == ST_CAS) ||
                        (st_q == ST_CP) || (st_q == ST_OPEN));
  assign dram_cas_n = (st_q != ST_CAS);
  assign dram_we_n  = 1'b1;
  assign oe_act     = (st_q == ST_CAS) ||
                      (EDO && page_rd_q &&
                       ((st_q == ST_CP) || (st_q == ST_OPEN) || (st_q == ST_COL)));
  assign dram_oe_n  = !oe_act;

  assert_cas_after_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> ($past(dram_ras_n) == 1'b0));
  assert_col_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));
  assert_open_row_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> row_open);
  assert_close_clears_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> !row_open);
  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  generate
    if (EDO) begin : g_edo_chk
      assert_edo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(rsp_data));
    end else begin : g_std_chk
      assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_data == '0));
    end
  endgenerate
endmodule

// File: tb/dram_page_reader_tb_top.sv
module dram_page_reader_tb_top;
  localparam int ROW_W = 8, COL_W = 8, DATA_W = 16;
  localparam int TRCD = 2, TCAS = 2, TCP = 1, TRP = 2, IDLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n;
  logic [DATA_W-1:0] rsp_data, dq;
  logic [7:0]        addr;
  logic              e_ready, e_valid, e_ras_n, e_cas_n, e_we_n, e_oe_n;
  logic [DATA_W-1:0] e_data;
  logic [7:0]        e_addr;

  dram_page_reader #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .TRCD(TRCD),
    .TCAS(TCAS), .TCP(TCP), .TRP(TRP), .IDLE_LIMIT(IDLE), .EDO(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dram_addr(addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_oe_n(oe_n), .dram_dq(dq));

  dram_page_reader #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .TRCD(TRCD),
    .TCAS(TCAS), .TCP(TCP), .TRP(TRP), .IDLE_LIMIT(IDLE), .EDO(1'b1)) dut_edo_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(e_ready),
    .req_row(req_row), .req_col(req_col), .rsp_valid(e_valid), .rsp_data(e_data),
    .dram_addr(e_addr), .dram_ras_n(e_ras_n), .dram_cas_n(e_cas_n), .dram_we_n(e_we_n),
    .dram_oe_n(e_oe_n), .dram_dq(dq));

  int total = 0, fails = 0;
  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input logic [7:0] r, input logic [7:0] c);
    return {r ^ 8'h5A, c + (r << 1)};
  endfunction

  // DRAM model: row latched at row-strobe fall, word driven while column strobe is low
  logic [7:0] mrow = '0;
  assign dq = (!cas_n) ? pat(mrow, addr) : '0;

  logic [DATA_W-1:0] exp_q[$];
  logic [DATA_W-1:0] last_edo = '0;
  bit prev_ras = 1, prev_cas = 1, ras_seen = 0, page_cas = 0;
  int ras_falls = 0, cas_low_run = 0, cas_high_run = 0, ras_low_run = 0, ras_high_run = 0;
  int we_err = 0, oe_err = 0, zero_err = 0, hold_err = 0, busy_err = 0, match_err = 0;
  int edo_oe_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (we_n !== 1'b1 || e_we_n !== 1'b1) we_err++;
      if (!oe_n && cas_n) oe_err++;
      if (!rsp_valid && rsp_data != '0) zero_err++;
      if (!e_valid && e_data != last_edo) hold_err++;
      if (e_valid) last_edo = e_data;
      if (!e_oe_n && e_cas_n && !e_ras_n) edo_oe_seen++;
      if (req_ready && !cas_n) busy_err++;
      if (e_ras_n != ras_n || e_cas_n != cas_n || e_addr != addr || e_ready != req_ready)
        match_err++;
      if (!ras_n && prev_ras) begin
        if (ras_seen) check(ras_high_run >= TRP, "R5 row precharge width", ras_high_run, TRP);
        ras_seen = 1; ras_falls++; mrow = addr; ras_low_run = 0; page_cas = 0;
      end
      if (ras_n && !prev_ras) ras_high_run = 0;
      if (!cas_n && prev_cas) begin
        check(ras_low_run >= TRCD + 1, "R2 row-to-column delay", ras_low_run, TRCD + 1);
        if (page_cas) check(cas_high_run >= TCP, "R4 column precharge", cas_high_run, TCP);
        cas_low_run = 0; page_cas = 1;
      end
      if (cas_n && !prev_cas) begin
        check(cas_low_run == TCAS, "R3 column strobe width", cas_low_run, TCAS);
        cas_high_run = 0;
      end
      if (!cas_n) cas_low_run++; else cas_high_run++;
      if (!ras_n) ras_low_run++; else ras_high_run++;
      if (rsp_valid) begin
        if (exp_q.size() == 0) check(0, "R8 unexpected response", rsp_data, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          check(rsp_data == e, "R8 response data", rsp_data, e);
          check(e_valid && e_data == e, "R10 extended-output data", e_data, e);
        end
      end
    end
    prev_ras = ras_n; prev_cas = cas_n;
  end

  task automatic send(input logic [7:0] r, input logic [7:0] c);
    req_valid = 1'b1; req_row = r; req_col = c;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(pat(r, c));
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R7 ready low after accept", req_ready, 0);
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
    check(exp_q.size() == 0, "R8 all responses returned", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n && we_n && oe_n, "R1 strobes high", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    check(addr == 0, "R1 address zero", addr, 0);
    check(!rsp_valid && req_ready, "R1 idle port", {rsp_valid, req_ready}, 1);

    // R4 page hits: one row strobe fall for four same-row reads
    f0 = ras_falls;
    send(8'd3, 8'd1); send(8'd3, 8'd2); send(8'd3, 8'd3); send(8'd3, 8'd4);
    drain();
    check(ras_falls - f0 == 1, "R4 single row open", ras_falls - f0, 1);

    // R5 row miss while open
    f0 = ras_falls;
    send(8'd3, 8'd5); send(8'd6, 8'd0); send(8'd6, 8'd7);
    drain();
    check(ras_falls - f0 == 1, "R5 one new row cycle", ras_falls - f0, 1);

    // R6 idle close timing
    repeat (IDLE + TRP + 6) @(negedge clk);
    req_valid = 1'b1; req_row = 8'd9; req_col = 8'd2;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(pat(8'd9, 8'd2));
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (TCP + IDLE - 1) @(negedge clk);
    check(!ras_n, "R6 page still open", ras_n, 0);
    @(negedge clk);
    check(ras_n, "R6 page closed by idle", ras_n, 1);

    // Random mix of hits, misses and idle closes
    for (int i = 0; i < 300; i++) begin
      repeat ($urandom_range(0, 11)) @(negedge clk);
      send(8'($urandom_range(0, 3)) * 8'd37, 8'($urandom));
    end
    drain();
    repeat (20) @(negedge clk);

    check(we_err == 0, "R2 write enable held high", we_err, 0);
    check(oe_err == 0, "R9 output enable only with column strobe", oe_err, 0);
    check(zero_err == 0, "R9 data zero outside pulse", zero_err, 0);
    check(hold_err == 0, "R10 data held between pulses", hold_err, 0);
    check(edo_oe_seen > 0, "R10 output enable kept low in page", edo_oe_seen, 1);
    check(busy_err == 0, "R7 ready low during column pulse", busy_err, 0);
    check(match_err == 0, "R3 both variants share strobe timing", match_err, 0);
    finish_run();
  end
endmodule